// File: doc/BRIEF.md
# Programmable Cascaded Clock Divider Chain

This block turns one fast master clock into two slower timing references. A first stage divides the master clock by 1 to 5 and produces an internal base rate. Two counters driven by that base rate then produce a serial bit-clock pulse and a sample-rate strobe. The serial pulse runs at the base rate divided by 1, 2, 4 or 8. The sample strobe runs at the base rate divided by 256, 512, 1024 or 2048.

Every divided rate is produced as a one-cycle enable pulse in the master clock domain, so the design uses a single clock. Downstream logic qualifies its own flops with these pulses. No generated clock is needed.

All three ratios come from one 8-bit configuration byte, loaded through a plain write strobe. A byte that has been written is held pending. It takes effect only at the next sample-strobe boundary, so no output period is ever cut short. The block has no data stream, so it has no valid/ready handshake. The configuration port is a plain strobe with no back-pressure: a write is accepted on every cycle in which `cfg_we` is high.

Top module: `clkdiv_chain`

## Requirements
- R1: While reset is held, both outputs are low. After reset the configuration byte is 0x00, which gives a base rate equal to the master clock, a serial pulse every 8 cycles and a sample strobe every 2048 cycles. The first strobe falls on the 2048th cycle after reset is released.
- R2: The base-rate field is bits 6:4. Codes 0, 1, 2, 3 and 4 divide the master clock by 1, 2, 3, 4 and 5. Every output period scales by that ratio.
- R3: Base-rate codes 5, 6 and 7 behave as divide-by-one.
- R4: The serial field is bits 3:2. Codes 0, 1, 2 and 3 give one serial pulse every 8, 4, 2 or 1 base ticks. Pulses are evenly spaced and each is one master cycle wide. With both dividers at 1 the pulse is high on every cycle.
- R5: The sample field is bits 1:0. Codes 0, 1, 2 and 3 give one strobe every 2048, 1024, 512 or 256 base ticks. The strobe is one master cycle wide.
- R6: Every sample strobe falls in a cycle that also carries a serial pulse. Each sample period holds exactly (sample ratio / serial ratio) serial pulses.
- R7: A byte written in the middle of a sample period leaves the rest of that period unchanged. It governs the next period.
- R8: A byte written in the same cycle as a sample strobe governs the period that starts right after that strobe.
- R9: When several bytes are written within one sample period, only the last one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte: [6:4] base ratio, [3:2] serial ratio, [1:0] sample ratio |
| sclk_out | output | 1 | Serial bit-clock enable pulse |
| sample_stb | output | 1 | Sample-rate strobe, one cycle wide |

## Verification
Two events can fall in the same cycle, and both are tested.

The first is a configuration write that lands on the exact cycle of a sample strobe. The bench watches the strobe on each falling edge and raises the write in that same cycle. It then checks that the very next period already follows the new byte.

The second is the sample strobe coinciding with a serial pulse. In every measured period the bench checks that the strobe cycle also carries a serial pulse. It also checks that the count and spacing of serial pulses match the arithmetic ratios, over a sweep of all base codes and all serial/sample combinations.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CFG_W         = 8;
  localparam int BASE_LSB      = 4;
  localparam int BASE_W        = 3;
  localparam int SER_LSB       = 2;
  localparam int SER_W         = 2;
  localparam int SMP_LSB       = 0;
  localparam int SMP_W         = 2;
  localparam int BASE_MAX      = 5;
  localparam int SER_LOG2_MAX  = 3;
  localparam int SMP_LOG2_MAX  = 11;
  localparam int BASE_CNT_W    = $clog2(BASE_MAX);
  localparam int SER_CNT_W     = SER_LOG2_MAX;
  localparam int SMP_CNT_W     = SMP_LOG2_MAX;

  // Base ratio minus one; codes beyond the last legal ratio fall back to 1.
  function automatic logic [BASE_CNT_W-1:0] base_m1(input logic [BASE_W-1:0] code);
    if (int'(code) < BASE_MAX) return BASE_CNT_W'(code);
    return '0;
  endfunction

  // Code zero selects the slowest serial rate.
  function automatic logic [SER_CNT_W-1:0] ser_m1(input logic [SER_W-1:0] code);
    return SER_CNT_W'((1 << (SER_LOG2_MAX - int'(code))) - 1);
  endfunction

  // Code zero selects the slowest sample rate.
  function automatic logic [SMP_CNT_W-1:0] smp_m1(input logic [SMP_W-1:0] code);
    return SMP_CNT_W'((1 << (SMP_LOG2_MAX - int'(code))) - 1);
  endfunction
endpackage

// File: rtl/cfg_hold.sv
module cfg_hold
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             boundary,
  output logic [CFG_W-1:0] active
);
  logic [CFG_W-1:0] pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      active  <= '0;
    end else begin
      if (we) pending <= wdata;
      // A write in the boundary cycle bypasses the pending copy.
      if (boundary) active <= we ? wdata : pending;
    end
  end

  a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(boundary) |-> $stable(active));
endmodule

// File: rtl/base_div.sv
module base_div
  import clkdiv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BASE_CNT_W-1:0] ratio_m1,
  output logic                  tick
);
  logic [BASE_CNT_W-1:0] cnt;

  assign tick = (cnt == ratio_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  a_r2_base_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ratio_m1);
endmodule

// File: rtl/rate_div.sv
module rate_div #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_in,
  input  logic [W-1:0] ratio_m1,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = en_in && (cnt == ratio_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (tick)  cnt <= '0;
    else if (en_in) cnt <= cnt + 1'b1;
  end

  // R4/R5: the count never passes the selected ratio.
  a_r4_rate_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ratio_m1);
endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             sclk_out,
  output logic             sample_stb
);
  logic [CFG_W-1:0] active;
  logic             base_tick;
  logic             ser_tick;
  logic             smp_tick;

  cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .boundary(smp_tick), .active(active)
  );

  base_div u_base (
    .clk(clk), .rst_n(rst_n),
    .ratio_m1(base_m1(active[BASE_LSB +: BASE_W])),
    .tick(base_tick)
  );

  rate_div #(.W(SER_CNT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .en_in(base_tick),
    .ratio_m1(ser_m1(active[SER_LSB +: SER_W])),
    .tick(ser_tick)
  );

  rate_div #(.W(SMP_CNT_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .en_in(base_tick),
    .ratio_m1(smp_m1(active[SMP_LSB +: SMP_W])),
    .tick(smp_tick)
  );

  assign sclk_out   = ser_tick;
  assign sample_stb = smp_tick;

  a_r6_stb_on_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> sclk_out);
  a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);
endmodule

// File: tb/clkdiv_chain_tb.sv
`timescale 1ns/1ps
module clkdiv_chain_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       sclk_out, sample_stb;
  logic       s_sclk, s_stb;
  int n_chk = 0, n_fail = 0, wd = 0;

  always #2.5 clk = ~clk;

  clkdiv_chain u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sclk_out(sclk_out), .sample_stb(sample_stb)
  );

  always @(posedge clk) begin
    wd++;
    if (wd >= 199000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <199000 cycles", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cfg_we = 1'b0;
    s_sclk = sclk_out;
    s_stb  = sample_stb;
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
  endtask

  function automatic logic [7:0] cfgb(input int mc, input int sc, input int dc);
    return {1'b0, 3'(mc), 2'(sc), 2'(dc)};
  endfunction

  task automatic wait_stb(input string req);
    int n = 0;
    do begin cyc(); n++; end while (!s_stb && n < 30000);
    chk(s_stb == 1'b1, req, "strobe reached", n, 0);
  endtask

  // Measures one sample period; c0 cycles of it have already elapsed.
  task automatic measure(input int m, input int s, input int d, input int c0, input string req);
    int c = c0;
    int pulses = c0 / (s * m);
    int last = pulses * s * m;
    int gap_bad = 0, gap_val = 0;
    bit stb_alone = 0;
    forever begin
      cyc();
      c++;
      if (s_sclk) begin
        pulses++;
        if (c - last != s * m) begin gap_bad++; gap_val = c - last; end
        last = c;
      end
      if (s_stb) begin
        if (!s_sclk) stb_alone = 1;
        break;
      end
      if (c > 30000) break;
    end
    chk(c == d * m, req, "sample period", c, d * m);
    chk(pulses == d / s, req, "serial pulses per period", pulses, d / s);
    chk(gap_bad == 0, req, "serial pulse spacing", gap_val, s * m);
    chk(!stb_alone, "R6", "strobe without serial pulse", 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk_out == 1'b0, "R1", "sclk_out in reset", int'(sclk_out), 0);
    chk(sample_stb == 1'b0, "R1", "sample_stb in reset", int'(sample_stb), 0);
    @(negedge clk);
    rst_n = 1'b1;
    measure(1, 8, 2048, 1, "R1");

    // Base-rate sweep: codes 0..4 are R2, codes 5..7 are R3.
    for (int mc = 0; mc < 8; mc++) begin
      cyc();
      wr(cfgb(mc, 3, 3));
      wait_stb(mc < 5 ? "R2" : "R3");
      measure(mc < 5 ? mc + 1 : 1, 1, 256, 0, mc < 5 ? "R2" : "R3");
    end

    // Serial and sample sweep (R4, R5).
    for (int sc = 0; sc < 4; sc++) begin
      for (int dc = 0; dc < 4; dc++) begin
        cyc();
        wr(cfgb(0, sc, dc));
        wait_stb("R5");
        measure(1, 8 >> sc, 2048 >> dc, 0, (sc == 3) ? "R4" : "R5");
      end
    end

    // R7: a mid-period write leaves the running period intact.
    cyc();
    wr(cfgb(1, 2, 3));
    wait_stb("R7");
    measure(2, 2, 256, 0, "R2");
    repeat (10) cyc();
    wr(cfgb(0, 0, 2));
    measure(2, 2, 256, 10, "R7");
    measure(1, 8, 512, 0, "R7");

    // R8: a write in the strobe cycle governs the next period.
    wr(cfgb(2, 1, 1));
    measure(3, 4, 1024, 0, "R8");

    // R9: the last of several writes wins.
    cyc();
    wr(cfgb(4, 0, 0));
    cyc();
    wr(cfgb(1, 3, 3));
    wait_stb("R9");
    measure(2, 1, 256, 0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule